// File: doc/BRIEF.md
# Quarter-Sample Luma Interpolator

This block forms one 4x4 tile of motion-compensated luma prediction at quarter-sample precision. For each tile it receives a 9x9 window of 8-bit reference pixels, already padded, whose top-left pixel lies two rows above and two columns left of the tile's first pixel. Two 2-bit fractions, horizontal and vertical, select one of sixteen sub-sample positions. The result is 16 predicted 8-bit pixels.

Inside, a six-tap half-sample filter is run along rows, along columns, and in two passes for the centre position. The first pass keeps full-precision intermediates for the centre. Quarter positions are the rounded average of two neighbouring samples, chosen per position. A small tile walker covers a square or rectangular region of 4, 8 or 16 pixels per side in raster order of 4x4 tiles. It tags each result with its tile coordinates and pulses a completion flag once the region's last tile has been handed on.

Windows enter through a valid/ready handshake. Results leave through a second one, one cycle after acceptance.

Top module: `qpel_luma_interp`

## Requirements
- R1: The position index is frac_y*4 + frac_x. Window pixel (row r, column c) sits at win_pix[8*(9*r+c) +: 8]. Tile pixel (i, j) corresponds to window pixel (i+2, j+2) and is driven on out_pix[8*(4*i+j) +: 8].
- R2: Index 0 outputs the integer pixels unchanged.
- R3: Index 2 outputs the horizontal half sample and index 8 outputs the vertical half sample. Each half sample is the 1,-5,20,20,-5,1 sum over window pixels at offsets -2..+3 from the tile pixel, to its right or below it respectively. The sum is then put through (s+16)>>5 and clamped to 0..255.
- R4: Index 10 outputs the centre sample. The same six-tap filter is run vertically over the unrounded horizontal sums of rows -2..+3, then (x+512)>>10 is applied and the result is clamped to 0..255.
- R5: Indices 1, 3, 4 and 12 each take the rounding average (p+q+1)>>1 of a half sample and an integer pixel. Index 1 uses the horizontal half and the same pixel. Index 3 uses the horizontal half and the pixel one column right. Index 4 uses the vertical half and the same pixel. Index 12 uses the vertical half and the pixel one row down.
- R6: Indices 5, 7, 13 and 15 average a horizontal half sample with a vertical half sample. For indices 7 and 15 the vertical half comes from one column right. For indices 13 and 15 the horizontal half comes from one row down.
- R7: Indices 6, 9, 11 and 14 average the centre sample with a half sample. Index 6 uses the horizontal half of the same row and index 14 the horizontal half of the next row. Index 9 uses the vertical half of the same column and index 11 the vertical half of the next column.
- R8: win_ready equals !out_valid || out_ready. A window taken while win_valid && win_ready appears, with out_valid high, on the following cycle, so latency is one cycle. After reset out_valid is low and win_ready is high.
- R9: While out_valid is high and out_ready is low, out_pix and the tile coordinates hold their values.
- R10: Tiles are walked left to right, then down by one tile row. Size codes 0, 1, 2 and 3 mean 4, 8, 16 and 16 pixels. The codes are sampled only when the first tile of a region is accepted, and out_tile_x/out_tile_y report each result's tile position.
- R11: out_done is high for exactly the cycle after the region's last tile was taken (out_valid && out_ready), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_w | input | 2 | Region width code (4/8/16/16) |
| size_h | input | 2 | Region height code (4/8/16/16) |
| frac_x | input | 2 | Horizontal quarter-sample fraction |
| frac_y | input | 2 | Vertical quarter-sample fraction |
| win_valid | input | 1 | Window presented |
| win_ready | output | 1 | Window can be taken |
| win_pix | input | 648 | 9x9 reference window, 8 bits per pixel |
| out_valid | output | 1 | Predicted tile available |
| out_ready | input | 1 | Consumer takes the tile |
| out_pix | output | 128 | 16 predicted pixels |
| out_tile_x | output | 2 | Tile column within the region |
| out_tile_y | output | 2 | Tile row within the region |
| out_done | output | 1 | Region completed pulse |

## Verification
Two functions can fall in the same cycle. The final tile of one region can leave on the output at the moment the first window of the next region is accepted and the walker samples new size codes. The bench provokes this by streaming regions back to back with out_ready mostly high. It judges the outcome with its behavioural model: out_done must rise only for the old region's last tile, and the new tile must carry coordinates (0,0) under the newly sampled size. Random output stalls also make a hold cycle coincide with a held-off window, and in that case the held data and win_ready are checked together.

// File: rtl/qli_pkg.sv
package qli_pkg;
    localparam int PW        = 8;
    localparam int WIN       = 9;
    localparam int TS        = 4;
    localparam int HW        = 16;
    localparam int CW        = 24;
    localparam int TCW       = 2;
    localparam int WIN_BITS  = WIN * WIN * PW;
    localparam int TILE_BITS = TS * TS * PW;

    typedef logic [PW-1:0]        pix_t;
    typedef logic signed [HW-1:0] inter_t;
    typedef logic signed [CW-1:0] wide_t;

    typedef pix_t   [WIN-1:0][WIN-1:0] win_t;
    typedef pix_t   [TS-1:0][TS-1:0]   tile_t;
    typedef pix_t   [WIN-1:0][TS:0]    vcol_t;
    typedef inter_t [WIN-1:0][TS-1:0]  hraw_t;
    typedef inter_t [TS:0][TS-1:0]     hsel_t;
    typedef inter_t [TS-1:0][TS:0]     vraw_t;

    typedef enum logic [1:0] {SZ_4, SZ_8, SZ_16, SZ_16_ALT} size_e;

    typedef struct packed {
        logic [TCW-1:0] tx;
        logic [TCW-1:0] ty;
        logic           last;
    } tag_t;

    function automatic wide_t px(input pix_t p);
        return wide_t'({1'b0, p});
    endfunction

    function automatic wide_t sx(input inter_t x);
        return CW'(x);
    endfunction

    function automatic wide_t tap6(input wide_t a, input wide_t b, input wide_t c,
                                   input wide_t d, input wide_t e, input wide_t f);
        return a - ((b <<< 2) + b) + ((c + d) <<< 4) + ((c + d) <<< 2)
                 - ((e <<< 2) + e) + f;
    endfunction

    function automatic pix_t sat8(input wide_t v);
        if (v[CW-1])           return '0;
        else if (|v[CW-2:PW])  return '1;
        else                   return v[PW-1:0];
    endfunction

    function automatic pix_t rnd5(input wide_t v);
        return sat8((v + CW'(16)) >>> 5);
    endfunction

    function automatic pix_t rnd10(input wide_t v);
        return sat8((v + CW'(512)) >>> 10);
    endfunction

    function automatic pix_t avg2(input pix_t p, input pix_t q);
        return PW'(({1'b0, p} + {1'b0, q} + 9'd1) >> 1);
    endfunction

    function automatic logic [TCW-1:0] span_last(input size_e s);
        case (s)
            SZ_4:    return TCW'(0);
            SZ_8:    return TCW'(1);
            default: return TCW'(3);
        endcase
    endfunction
endpackage

// File: rtl/qli_hfilt.sv
module qli_hfilt
    import qli_pkg::*;
(
    input  win_t  win,
    output hraw_t h_raw
);
    for (genvar r = 0; r < WIN; r++) begin : g_row
        for (genvar j = 0; j < TS; j++) begin : g_col
            assign h_raw[r][j] = HW'(tap6(px(win[r][j]),   px(win[r][j+1]),
                                          px(win[r][j+2]), px(win[r][j+3]),
                                          px(win[r][j+4]), px(win[r][j+5])));
        end
    end
endmodule

// File: rtl/qli_vfilt.sv
module qli_vfilt
    import qli_pkg::*;
(
    input  vcol_t cols,
    output vraw_t v_raw
);
    for (genvar i = 0; i < TS; i++) begin : g_row
        for (genvar k = 0; k <= TS; k++) begin : g_col
            assign v_raw[i][k] = HW'(tap6(px(cols[i][k]),   px(cols[i+1][k]),
                                          px(cols[i+2][k]), px(cols[i+3][k]),
                                          px(cols[i+4][k]), px(cols[i+5][k])));
        end
    end
endmodule

// File: rtl/qli_centre.sv
module qli_centre
    import qli_pkg::*;
(
    input  hraw_t h_raw,
    output tile_t c_pix
);
    for (genvar i = 0; i < TS; i++) begin : g_row
        for (genvar j = 0; j < TS; j++) begin : g_col
            assign c_pix[i][j] = rnd10(tap6(sx(h_raw[i][j]),   sx(h_raw[i+1][j]),
                                            sx(h_raw[i+2][j]), sx(h_raw[i+3][j]),
                                            sx(h_raw[i+4][j]), sx(h_raw[i+5][j])));
        end
    end
endmodule

// File: rtl/qli_select.sv
module qli_select
    import qli_pkg::*;
(
    input  logic [3:0] idx,
    input  tile_t      g_same,
    input  tile_t      g_right,
    input  tile_t      g_below,
    input  hsel_t      h_raw,
    input  vraw_t      v_raw,
    input  tile_t      c_pix,
    output tile_t      pred
);
    for (genvar i = 0; i < TS; i++) begin : g_row
        for (genvar j = 0; j < TS; j++) begin : g_col
            pix_t hh, hd, vh, vr, cc, g, gr, gd;
            assign g  = g_same[i][j];
            assign gr = g_right[i][j];
            assign gd = g_below[i][j];
            assign hh = rnd5(sx(h_raw[i][j]));
            assign hd = rnd5(sx(h_raw[i+1][j]));
            assign vh = rnd5(sx(v_raw[i][j]));
            assign vr = rnd5(sx(v_raw[i][j+1]));
            assign cc = c_pix[i][j];

            always_comb begin
                case (idx)
                    4'd0:    pred[i][j] = g;
                    4'd1:    pred[i][j] = avg2(hh, g);
                    4'd2:    pred[i][j] = hh;
                    4'd3:    pred[i][j] = avg2(hh, gr);
                    4'd4:    pred[i][j] = avg2(vh, g);
                    4'd5:    pred[i][j] = avg2(hh, vh);
                    4'd6:    pred[i][j] = avg2(cc, hh);
                    4'd7:    pred[i][j] = avg2(hh, vr);
                    4'd8:    pred[i][j] = vh;
                    4'd9:    pred[i][j] = avg2(cc, vh);
                    4'd10:   pred[i][j] = cc;
                    4'd11:   pred[i][j] = avg2(cc, vr);
                    4'd12:   pred[i][j] = avg2(vh, gd);
                    4'd13:   pred[i][j] = avg2(hd, vh);
                    4'd14:   pred[i][j] = avg2(cc, hd);
                    default: pred[i][j] = avg2(hd, vr);
                endcase
            end
        end
    end
endmodule

// File: rtl/qli_tile_seq.sv
module qli_tile_seq
    import qli_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    input  logic [1:0] size_w,
    input  logic [1:0] size_h,
    output tag_t       tag
);
    logic [TCW-1:0] tx, ty, wl_q, hl_q, wl, hl;
    logic           first;

    assign first = (tx == '0) && (ty == '0);
    assign wl    = first ? span_last(size_e'(size_w)) : wl_q;
    assign hl    = first ? span_last(size_e'(size_h)) : hl_q;

    assign tag.tx   = tx;
    assign tag.ty   = ty;
    assign tag.last = (tx == wl) && (ty == hl);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx   <= '0;
            ty   <= '0;
            wl_q <= '0;
            hl_q <= '0;
        end else if (adv) begin
            if (first) begin
                wl_q <= wl;
                hl_q <= hl;
            end
            if (tx == wl) begin
                tx <= '0;
                ty <= (ty == hl) ? '0 : ty + 1'b1;
            end else begin
                tx <= tx + 1'b1;
            end
        end
    end

    // R10: after the region's last tile the walker is back at the origin
    a_r10_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && tag.last) |=> (tx == '0 && ty == '0));

    // R10: stepping a non-final tile never returns to the origin
    a_r10_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !tag.last) |=> !(tx == '0 && ty == '0));
endmodule

// File: rtl/qpel_luma_interp.sv
module qpel_luma_interp
    import qli_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           size_w,
    input  logic [1:0]           size_h,
    input  logic [1:0]           frac_x,
    input  logic [1:0]           frac_y,
    input  logic                 win_valid,
    output logic                 win_ready,
    input  logic [WIN_BITS-1:0]  win_pix,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [TILE_BITS-1:0] out_pix,
    output logic [TCW-1:0]       out_tile_x,
    output logic [TCW-1:0]       out_tile_y,
    output logic                 out_done
);
    win_t  win;
    vcol_t vcols;
    hraw_t h_raw;
    hsel_t h_sel;
    vraw_t v_raw;
    tile_t g_same, g_right, g_below, c_pix, pred, pix_q;
    tag_t  tag, tag_q;
    logic  valid_q, done_q, accept;

    assign win = win_t'(win_pix);

    for (genvar r = 0; r < WIN; r++) begin : g_vcol
        for (genvar k = 0; k <= TS; k++) begin : g_k
            assign vcols[r][k] = win[r][k+2];
        end
    end

    for (genvar i = 0; i < TS; i++) begin : g_slice
        for (genvar j = 0; j < TS; j++) begin : g_j
            assign g_same[i][j]  = win[i+2][j+2];
            assign g_right[i][j] = win[i+2][j+3];
            assign g_below[i][j] = win[i+3][j+2];
        end
    end

    for (genvar r = 0; r <= TS; r++) begin : g_hsel
        assign h_sel[r] = h_raw[r+2];
    end

    qli_hfilt  u_hfilt  (.win(win), .h_raw(h_raw));
    qli_vfilt  u_vfilt  (.cols(vcols), .v_raw(v_raw));
    qli_centre u_centre (.h_raw(h_raw), .c_pix(c_pix));
    qli_select u_select (.idx({frac_y, frac_x}), .g_same(g_same), .g_right(g_right),
                         .g_below(g_below), .h_raw(h_sel), .v_raw(v_raw),
                         .c_pix(c_pix), .pred(pred));
    qli_tile_seq u_seq  (.clk(clk), .rst(rst), .adv(accept),
                         .size_w(size_w), .size_h(size_h), .tag(tag));

    assign win_ready = !valid_q || out_ready;
    assign accept    = win_valid && win_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            pix_q   <= '0;
            tag_q   <= '0;
        end else begin
            done_q <= valid_q && out_ready && tag_q.last;
            if (accept) begin
                valid_q <= 1'b1;
                pix_q   <= pred;
                tag_q   <= tag;
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_pix    = TILE_BITS'(pix_q);
    assign out_tile_x = tag_q.tx;
    assign out_tile_y = tag_q.ty;
    assign out_done   = done_q;

    // R8: an accepted window is on the output the next cycle
    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        (win_valid && win_ready) |=> out_valid);

    // R9: a stalled result stays put
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)
                                       && $stable(out_tile_x) && $stable(out_tile_y)));

    // R2: the integer position passes the centre pixels through
    a_r2_copy: assert property (@(posedge clk) disable iff (rst)
        (win_valid && win_ready && frac_x == 2'd0 && frac_y == 2'd0)
            |=> (out_pix == TILE_BITS'($past(g_same))));

    // R11: completion only follows a hand-off of a result
    a_r11_done: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(out_valid && out_ready));
endmodule

// File: tb/qpel_luma_interp_bench.sv
module qpel_luma_interp_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   size_w, size_h, frac_x, frac_y;
    logic         win_valid, win_ready, out_valid, out_ready, out_done;
    logic [647:0] win_pix;
    logic [127:0] out_pix;
    logic [1:0]   out_tile_x, out_tile_y;

    always #5 clk = ~clk;

    qpel_luma_interp u_qpel_luma_interp (
        .clk(clk), .rst(rst), .size_w(size_w), .size_h(size_h),
        .frac_x(frac_x), .frac_y(frac_y), .win_valid(win_valid),
        .win_ready(win_ready), .win_pix(win_pix), .out_valid(out_valid),
        .out_ready(out_ready), .out_pix(out_pix), .out_tile_x(out_tile_x),
        .out_tile_y(out_tile_y), .out_done(out_done));

    int errors = 0;
    int checks = 0;
    int W [9][9];

    bit m_valid = 0, m_done = 0, m_last = 0, m_held = 0, last_acc = 0;
    logic [127:0] m_pix = '0;
    int m_tx = 0, m_ty = 0, m_idx = 0;
    int s_tx = 0, s_ty = 0, s_wl = 0, s_hl = 0;

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic int clip8(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction
    function automatic int t6(input int a, input int b, input int c,
                              input int d, input int e, input int f);
        return a - 5*b + 20*c + 20*d - 5*e + f;
    endfunction
    function automatic int hraw(input int r, input int c);
        return t6(W[r][c-2], W[r][c-1], W[r][c], W[r][c+1], W[r][c+2], W[r][c+3]);
    endfunction
    function automatic int vraw(input int r, input int c);
        return t6(W[r-2][c], W[r-1][c], W[r][c], W[r+1][c], W[r+2][c], W[r+3][c]);
    endfunction
    function automatic int hh(input int r, input int c);
        return clip8((hraw(r, c) + 16) >>> 5);
    endfunction
    function automatic int vh(input int r, input int c);
        return clip8((vraw(r, c) + 16) >>> 5);
    endfunction
    function automatic int cen(input int r, input int c);
        return clip8((t6(hraw(r-2, c), hraw(r-1, c), hraw(r, c), hraw(r+1, c),
                         hraw(r+2, c), hraw(r+3, c)) + 512) >>> 10);
    endfunction
    function automatic int av(input int p, input int q);
        return (p + q + 1) >> 1;
    endfunction

    // R1: index = frac_y*4 + frac_x, tile pixel (i,j) = window (i+2,j+2)
    function automatic logic [127:0] model_tile(input int idx);
        logic [127:0] t = '0;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                int r = i + 2;
                int c = j + 2;
                int v;
                case (idx)
                    0:  v = W[r][c];
                    1:  v = av(hh(r, c), W[r][c]);
                    2:  v = hh(r, c);
                    3:  v = av(hh(r, c), W[r][c+1]);
                    4:  v = av(vh(r, c), W[r][c]);
                    5:  v = av(hh(r, c), vh(r, c));
                    6:  v = av(cen(r, c), hh(r, c));
                    7:  v = av(hh(r, c), vh(r, c+1));
                    8:  v = vh(r, c);
                    9:  v = av(cen(r, c), vh(r, c));
                    10: v = cen(r, c);
                    11: v = av(cen(r, c), vh(r, c+1));
                    12: v = av(vh(r, c), W[r+1][c]);
                    13: v = av(hh(r+1, c), vh(r, c));
                    14: v = av(cen(r, c), hh(r+1, c));
                    default: v = av(hh(r+1, c), vh(r, c+1));
                endcase
                t[8*(4*i+j) +: 8] = 8'(v);
            end
        end
        return t;
    endfunction

    function automatic string req_of(input int idx);
        case (idx)
            0:             return "R2";
            2, 8:          return "R3";
            10:            return "R4";
            1, 3, 4, 12:   return "R5";
            5, 7, 13, 15:  return "R6";
            default:       return "R7";
        endcase
    endfunction

    function automatic int span(input logic [1:0] s);
        return (s == 2'd0) ? 0 : ((s == 2'd1) ? 1 : 3);
    endfunction

    task automatic fill(input int mode);
        for (int r = 0; r < 9; r++) begin
            for (int c = 0; c < 9; c++) begin
                case (mode)
                    0: W[r][c] = int'($urandom % 256);
                    1: W[r][c] = 255;
                    2: W[r][c] = ((r + c) % 2 == 1) ? 255 : 0;
                    3: W[r][c] = 0;
                    4: W[r][c] = (c < 4) ? 0 : 255;
                    default: W[r][c] = (r * 30 + c * 7) % 256;
                endcase
                win_pix[8*(9*r+c) +: 8] = 8'(W[r][c]);
            end
        end
    endtask

    task automatic step(input bit v, input bit rdy);
        bit acc, nd, exp_rdy;
        int idx;
        win_valid = v;
        out_ready = rdy;
        #1;
        exp_rdy = !m_valid || rdy;
        chk(win_ready === exp_rdy,
            $sformatf("R8 win_ready act=%0b exp=%0b", win_ready, exp_rdy));
        acc = v && exp_rdy;
        nd  = m_valid && rdy && m_last;
        idx = int'(frac_y) * 4 + int'(frac_x);
        if (acc) begin
            if (s_tx == 0 && s_ty == 0) begin
                s_wl = span(size_w);
                s_hl = span(size_h);
            end
            m_pix  = model_tile(idx);
            m_idx  = idx;
            m_tx   = s_tx;
            m_ty   = s_ty;
            m_last = (s_tx == s_wl) && (s_ty == s_hl);
            if (s_tx == s_wl) begin
                s_tx = 0;
                s_ty = (s_ty == s_hl) ? 0 : s_ty + 1;
            end else begin
                s_tx++;
            end
            m_valid = 1;
            m_held  = 0;
        end else if (rdy) begin
            m_valid = 0;
        end else begin
            m_held = m_valid;
        end
        m_done   = nd;
        last_acc = acc;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid === m_valid,
            $sformatf("R8 out_valid act=%0b exp=%0b", out_valid, m_valid));
        chk(out_done === m_done,
            $sformatf("R11 out_done act=%0b exp=%0b", out_done, m_done));
        if (m_valid) begin
            chk(out_pix === m_pix,
                $sformatf("%s%s idx=%0d act=%h exp=%h", m_held ? "R9 " : "",
                          req_of(m_idx), m_idx, out_pix, m_pix));
            chk(int'(out_tile_x) == m_tx && int'(out_tile_y) == m_ty,
                $sformatf("R10 tile act=(%0d,%0d) exp=(%0d,%0d)",
                          out_tile_x, out_tile_y, m_tx, m_ty));
        end
    endtask

    initial begin
        int sw [7] = '{0, 1, 2, 0, 3, 2, 1};
        int sh [7] = '{0, 1, 0, 2, 1, 2, 3};
        int tileno = 0;
        rst = 1'b1;
        win_valid = 1'b0;
        out_ready = 1'b0;
        size_w = '0; size_h = '0; frac_x = '0; frac_y = '0;
        win_pix = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(out_valid === 1'b0, $sformatf("R8 reset out_valid act=%0b exp=0", out_valid));
        chk(out_done === 1'b0, $sformatf("R11 reset out_done act=%0b exp=0", out_done));
        chk(win_ready === 1'b1, $sformatf("R8 reset win_ready act=%0b exp=1", win_ready));
        for (int rg = 0; rg < 7; rg++) begin
            int n = (span(2'(sw[rg])) + 1) * (span(2'(sh[rg])) + 1);
            for (int t = 0; t < n; t++) begin
                // R10: size codes after the first tile must be ignored
                size_w = (t == 0) ? 2'(sw[rg]) : 2'($urandom);
                size_h = (t == 0) ? 2'(sh[rg]) : 2'($urandom);
                frac_x = 2'(tileno % 4);
                frac_y = 2'((tileno / 4) % 4);
                fill(tileno % 6);
                if ($urandom % 4 == 0) step(1'b0, 1'($urandom));
                do step(1'b1, ($urandom % 4) != 0); while (!last_acc);
                tileno++;
            end
        end
        step(1'b0, 1'b0);
        repeat (4) step(1'b0, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule